// File: doc/BRIEF.md
# MSI Interrupt Request Generator

This block turns an interrupt request from application logic into one descriptor for a message-signalled interrupt, which a packet builder downstream then sends as a posted memory write. The requester gives a traffic class, a vector number and a function index with the request. The block reads that function's interrupt configuration: an enable bit, a 64-bit target address, a 16-bit data word and a 3-bit field that sets how many vectors are allowed. From these it forms the address and the data. The vector number goes only into the low data bits that the vector-count field allows. The other data bits keep their configured value.

The descriptor leaves on a valid/ready interface. Once `desc_valid` is high, every descriptor field stays unchanged until a cycle in which `desc_ready` is also high. That cycle is the transfer, and downstream may stall it for any number of cycles. Only one descriptor can be outstanding. While one is waiting, and in the acknowledge cycle that follows it, new requests are ignored. The request line may be a single-cycle pulse, or it may be held high until `req_ack` is seen. If the selected function has interrupts disabled, the request is still acknowledged, but no descriptor is produced and `req_drop` pulses instead.

Top module: `msi_req_gen`

## Requirements
- R1: After reset, `desc_valid`, `req_ack` and `req_drop` are low.
- R2: A request accepted while idle for an enabled function raises `desc_valid` one cycle later. The descriptor carries that function's configured address, the requested traffic class and the function index. Function n uses configuration slice n.
- R3: Data bits [k-1:0] come from the vector number and bits [15:k] from the configured data. k is set by the vector-count field: 0 gives 0 bits, 1 gives 1 bit, 2 gives 2 bits, 3 gives 3 bits, 4 gives 4 bits, 5 gives 5 bits, and 6 or 7 give 5 bits.
- R4: While `desc_valid` is high and `desc_ready` is low, `desc_valid` stays high and every descriptor field holds its value. This holds even if the configuration changes.
- R5: `req_ack` is high for exactly one cycle, in the cycle after the transfer (`desc_valid` and `desc_ready` both high), with `req_drop` low.
- R6: A request for a disabled function gives `req_ack` and `req_drop` high together for one cycle, in the cycle after the request. `desc_valid` stays low.
- R7: A request is ignored while `desc_valid` is high or `req_ack` is high. A request held high until the acknowledge is seen produces exactly one descriptor.
- R8: `desc_addr64` is 1 when address bits [63:32] are nonzero, and 0 otherwise.
- R9: Every traffic class value from 0 to 7 is passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Interrupt request, pulse or level |
| req_tc | input | 3 | Traffic class for the message |
| req_vec | input | 5 | Vector number |
| req_func | input | 3 | Function index |
| req_ack | output | 1 | One-cycle acknowledge |
| req_drop | output | 1 | One-cycle pulse: request discarded, function disabled |
| cfg_en | input | 8 | Per-function interrupt enable |
| cfg_addr | input | 512 | Per-function address, function n at bits [64n+63:64n] |
| cfg_data | input | 128 | Per-function data word, function n at bits [16n+15:16n] |
| cfg_mme | input | 24 | Per-function vector-count field, function n at bits [3n+2:3n] |
| desc_valid | output | 1 | Descriptor valid |
| desc_ready | input | 1 | Downstream ready |
| desc_addr | output | 64 | Message address |
| desc_data | output | 16 | Message data |
| desc_tc | output | 3 | Message traffic class |
| desc_func | output | 3 | Originating function |
| desc_addr64 | output | 1 | 1: 64-bit address format, 0: 32-bit |

## Verification
The assertions check every cycle that stalled descriptors hold steady. They also check that the acknowledge is a single pulse that follows each transfer, that a drop never appears alongside a pending descriptor, and that the address-format flag matches the upper address bits. Only the bench scenarios can show correct values. That covers the per-function selection, the data merge for each vector-count setting including the clamped codes, and the pass-through of every traffic class. The bench also covers requests ignored while busy and the single descriptor produced by a held request.

// File: rtl/msi_req_pkg.sv
package msi_req_pkg;

  // Number of low data bits taken from the vector, limited to the vector width.
  function automatic int vec_bits(input logic [2:0] mme, input int cap);
    int n;
    n = int'(mme);
    if (n > cap) n = cap;
    return n;
  endfunction

endpackage

// File: rtl/msi_cfg_sel.sv
module msi_cfg_sel #(
  parameter int NUM_FUNC = 8,
  parameter int FUNC_W   = 3,
  parameter int ADDR_W   = 64,
  parameter int DATA_W   = 16,
  parameter int MME_W    = 3
) (
  input  logic [FUNC_W-1:0]          sel,
  input  logic [NUM_FUNC-1:0]        all_en,
  input  logic [NUM_FUNC*ADDR_W-1:0] all_addr,
  input  logic [NUM_FUNC*DATA_W-1:0] all_data,
  input  logic [NUM_FUNC*MME_W-1:0]  all_mme,
  output logic                       en,
  output logic [ADDR_W-1:0]          addr,
  output logic [DATA_W-1:0]          data,
  output logic [MME_W-1:0]           mme
);
  logic [ADDR_W-1:0] addr_a [NUM_FUNC];
  logic [DATA_W-1:0] data_a [NUM_FUNC];
  logic [MME_W-1:0]  mme_a  [NUM_FUNC];

  for (genvar g = 0; g < NUM_FUNC; g++) begin : g_unpack
    assign addr_a[g] = all_addr[g*ADDR_W +: ADDR_W];
    assign data_a[g] = all_data[g*DATA_W +: DATA_W];
    assign mme_a[g]  = all_mme[g*MME_W +: MME_W];
  end

  // Index outside the implemented range reads as a disabled function.
  always_comb begin
    en   = 1'b0;
    addr = '0;
    data = '0;
    mme  = '0;
    for (int f = 0; f < NUM_FUNC; f++) begin
      if (sel == FUNC_W'(f)) begin
        en   = all_en[f];
        addr = addr_a[f];
        data = data_a[f];
        mme  = mme_a[f];
      end
    end
  end
endmodule

// File: rtl/msi_vec_merge.sv
module msi_vec_merge #(
  parameter int DATA_W = 16,
  parameter int VEC_W  = 5
) (
  input  logic [DATA_W-1:0] base,
  input  logic [VEC_W-1:0]  vec,
  input  logic [2:0]        mme,
  output logic [DATA_W-1:0] merged
);
  import msi_req_pkg::*;

  localparam int CAP = (VEC_W < DATA_W) ? VEC_W : DATA_W;

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] vec_ext;
  int                nbits;

  assign vec_ext = {{(DATA_W-VEC_W){1'b0}}, vec};

  always_comb begin
    nbits = vec_bits(mme, CAP);
    for (int i = 0; i < DATA_W; i++) mask[i] = (i < nbits);
  end

  assign merged = (base & ~mask) | (vec_ext & mask);
endmodule

// File: rtl/msi_req_gen.sv
module msi_req_gen #(
  parameter int NUM_FUNC = 8,
  parameter int FUNC_W   = 3,
  parameter int TC_W     = 3,
  parameter int VEC_W    = 5,
  parameter int ADDR_W   = 64,
  parameter int DATA_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [TC_W-1:0]            req_tc,
  input  logic [VEC_W-1:0]           req_vec,
  input  logic [FUNC_W-1:0]          req_func,
  output logic                       req_ack,
  output logic                       req_drop,
  input  logic [NUM_FUNC-1:0]        cfg_en,
  input  logic [NUM_FUNC*ADDR_W-1:0] cfg_addr,
  input  logic [NUM_FUNC*DATA_W-1:0] cfg_data,
  input  logic [NUM_FUNC*3-1:0]      cfg_mme,
  output logic                       desc_valid,
  input  logic                       desc_ready,
  output logic [ADDR_W-1:0]          desc_addr,
  output logic [DATA_W-1:0]          desc_data,
  output logic [TC_W-1:0]            desc_tc,
  output logic [FUNC_W-1:0]          desc_func,
  output logic                       desc_addr64
);
  localparam int HALF_W = ADDR_W / 2;

  logic              sel_en;
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_data;
  logic [2:0]        sel_mme;
  logic [DATA_W-1:0] merged;
  logic              busy, take;

  msi_cfg_sel #(
    .NUM_FUNC(NUM_FUNC), .FUNC_W(FUNC_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .MME_W(3)
  ) u_sel (
    .sel(req_func), .all_en(cfg_en), .all_addr(cfg_addr),
    .all_data(cfg_data), .all_mme(cfg_mme),
    .en(sel_en), .addr(sel_addr), .data(sel_data), .mme(sel_mme)
  );

  msi_vec_merge #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_merge (
    .base(sel_data), .vec(req_vec), .mme(sel_mme), .merged(merged)
  );

  // One message in flight; the acknowledge cycle also blocks so a held
  // request is not taken twice.
  assign busy = desc_valid | req_ack;
  assign take = req_valid & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      desc_valid  <= 1'b0;
      req_ack     <= 1'b0;
      req_drop    <= 1'b0;
      desc_addr   <= '0;
      desc_data   <= '0;
      desc_tc     <= '0;
      desc_func   <= '0;
      desc_addr64 <= 1'b0;
    end else begin
      req_ack  <= 1'b0;
      req_drop <= 1'b0;
      if (desc_valid && desc_ready) begin
        desc_valid <= 1'b0;
        req_ack    <= 1'b1;
      end else if (take) begin
        if (sel_en) begin
          desc_valid  <= 1'b1;
          desc_addr   <= sel_addr;
          desc_data   <= merged;
          desc_tc     <= req_tc;
          desc_func   <= req_func;
          desc_addr64 <= |sel_addr[ADDR_W-1:HALF_W];
        end else begin
          req_ack  <= 1'b1;
          req_drop <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/msi_req_gen_chk.sv
module msi_req_gen_chk #(
  parameter int TC_W   = 3,
  parameter int FUNC_W = 3,
  parameter int ADDR_W = 64,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ack,
  input logic              req_drop,
  input logic              desc_valid,
  input logic              desc_ready,
  input logic [ADDR_W-1:0] desc_addr,
  input logic [DATA_W-1:0] desc_data,
  input logic [TC_W-1:0]   desc_tc,
  input logic [FUNC_W-1:0] desc_func,
  input logic              desc_addr64
);
  localparam int HALF_W = ADDR_W / 2;

  a_r2_rise_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(desc_valid) |-> $past(req_valid));

  a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !desc_ready |=> desc_valid && $stable(desc_addr) &&
      $stable(desc_data) && $stable(desc_tc) && $stable(desc_func) &&
      $stable(desc_addr64));

  a_r5_ack_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && desc_ready |=> req_ack && !req_drop);

  a_r5_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);

  a_r6_drop_alone: assert property (@(posedge clk) disable iff (!rst_n)
    req_drop |-> req_ack && !desc_valid);

  a_r7_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> !req_ack);

  a_r8_format_flag: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> desc_addr64 == (|desc_addr[ADDR_W-1:HALF_W]));
endmodule

bind msi_req_gen msi_req_gen_chk #(
  .TC_W(TC_W), .FUNC_W(FUNC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ack(req_ack),
  .req_drop(req_drop), .desc_valid(desc_valid), .desc_ready(desc_ready),
  .desc_addr(desc_addr), .desc_data(desc_data), .desc_tc(desc_tc),
  .desc_func(desc_func), .desc_addr64(desc_addr64)
);

// File: tb/sim_msi_req_gen.sv
module sim_msi_req_gen;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [2:0]   req_tc = '0;
  logic [4:0]   req_vec = '0;
  logic [2:0]   req_func = '0;
  logic         req_ack, req_drop;
  logic [7:0]   cfg_en = '0;
  logic [511:0] cfg_addr = '0;
  logic [127:0] cfg_data = '0;
  logic [23:0]  cfg_mme = '0;
  logic         desc_valid;
  logic         desc_ready = 1'b0;
  logic [63:0]  desc_addr;
  logic [15:0]  desc_data;
  logic [2:0]   desc_tc, desc_func;
  logic         desc_addr64;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  msi_req_gen u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tc(req_tc),
    .req_vec(req_vec), .req_func(req_func), .req_ack(req_ack),
    .req_drop(req_drop), .cfg_en(cfg_en), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .cfg_mme(cfg_mme), .desc_valid(desc_valid),
    .desc_ready(desc_ready), .desc_addr(desc_addr), .desc_data(desc_data),
    .desc_tc(desc_tc), .desc_func(desc_func), .desc_addr64(desc_addr64)
  );

  // {func, vec, tc, mme, hi, cfg data, expected data}
  localparam logic [46:0] TBL [8] = '{
    {3'd0, 5'h1F, 3'd0, 3'd0, 1'b0, 16'hABCD, 16'hABCD},
    {3'd1, 5'h1F, 3'd7, 3'd1, 1'b0, 16'h1230, 16'h1231},
    {3'd2, 5'h1F, 3'd3, 3'd2, 1'b0, 16'hFFF0, 16'hFFF3},
    {3'd3, 5'h15, 3'd5, 3'd3, 1'b1, 16'h0000, 16'h0005},
    {3'd4, 5'h0A, 3'd1, 3'd4, 1'b0, 16'hFFFF, 16'hFFFA},
    {3'd5, 5'h13, 3'd2, 3'd5, 1'b1, 16'h8000, 16'h8013},
    {3'd6, 5'h1F, 3'd4, 3'd6, 1'b0, 16'h0000, 16'h001F},
    {3'd7, 5'h00, 3'd6, 3'd7, 1'b1, 16'h00FF, 16'h00E0}
  };

  function automatic logic [63:0] addr_of(input int f, input logic hi);
    logic [31:0] up;
    up = hi ? (32'hA000_0000 + 32'(f)) : 32'h0;
    return {up, 32'hFEE0_0000 + 32'(f * 16)};
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_defaults();
    for (int f = 0; f < 8; f++) begin
      cfg_en[f]               = 1'b1;
      cfg_addr[f*64 +: 64]    = addr_of(f, 1'b0);
      cfg_data[f*16 +: 16]    = 16'h5A5A;
      cfg_mme[f*3 +: 3]       = 3'd0;
    end
  endtask

  task automatic pulse_req(input logic [2:0] f, input logic [4:0] v,
                           input logic [2:0] tc);
    req_func = f; req_vec = v; req_tc = tc; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    cfg_defaults();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(desc_valid == 1'b0 && req_ack == 1'b0 && req_drop == 1'b0,
        "R1 reset outputs", {61'b0, desc_valid, req_ack, req_drop}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int r = 0; r < 8; r++) begin
      logic [2:0]  f;
      logic [4:0]  v;
      logic [2:0]  tc, mme;
      logic        hi;
      logic [15:0] dat, exp_d;
      logic [63:0] ea;
      {f, v, tc, mme, hi, dat, exp_d} = TBL[r];
      cfg_defaults();
      ea = addr_of(int'(f), hi);
      cfg_addr[int'(f)*64 +: 64] = ea;
      cfg_data[int'(f)*16 +: 16] = dat;
      cfg_mme[int'(f)*3 +: 3]    = mme;
      pulse_req(f, v, tc);
      chk(desc_valid, "R2 valid after request", {63'b0, desc_valid}, 64'h1);
      chk(desc_addr == ea, "R2 address", desc_addr, ea);
      chk(desc_func == f, "R2 function", {61'b0, desc_func}, {61'b0, f});
      chk(desc_data == exp_d, "R3 data merge", {48'b0, desc_data}, {48'b0, exp_d});
      chk(desc_tc == tc, "R9 traffic class", {61'b0, desc_tc}, {61'b0, tc});
      chk(desc_addr64 == hi, "R8 address format", {63'b0, desc_addr64}, {63'b0, hi});
      // stall one cycle while the configuration changes
      cfg_data[int'(f)*16 +: 16] = ~dat;
      cfg_addr[int'(f)*64 +: 64] = 64'h0;
      @(negedge clk);
      chk(desc_valid && desc_data == exp_d && desc_addr == ea,
          "R4 hold under stall", {48'b0, desc_data}, {48'b0, exp_d});
      chk(req_ack == 1'b0, "R5 no ack before transfer", {63'b0, req_ack}, 64'h0);
      desc_ready = 1'b1;
      @(negedge clk);
      desc_ready = 1'b0;
      chk(req_ack && !req_drop && !desc_valid, "R5 ack after transfer",
          {62'b0, req_ack, req_drop}, 64'h2);
      @(negedge clk);
      chk(req_ack == 1'b0, "R5 ack single cycle", {63'b0, req_ack}, 64'h0);
    end

    // R6: disabled function
    cfg_defaults();
    cfg_en[2] = 1'b0;
    pulse_req(3'd2, 5'h3, 3'd1);
    chk(req_ack && req_drop && !desc_valid, "R6 drop on disabled",
        {61'b0, req_ack, req_drop, desc_valid}, 64'h6);
    @(negedge clk);
    chk(!req_ack && !req_drop && !desc_valid, "R6 drop single cycle",
        {61'b0, req_ack, req_drop, desc_valid}, 64'h0);

    // R7: request while pending is ignored
    cfg_defaults();
    pulse_req(3'd1, 5'h0, 3'd0);
    pulse_req(3'd4, 5'h1, 3'd3);
    chk(desc_func == 3'd1 && desc_tc == 3'd0, "R7 pending not replaced",
        {61'b0, desc_func}, 64'h1);
    desc_ready = 1'b1;
    @(negedge clk);
    desc_ready = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(desc_valid == 1'b0, "R7 ignored request left no descriptor",
        {63'b0, desc_valid}, 64'h0);

    // R7: held request yields exactly one descriptor
    req_func = 3'd5; req_vec = 5'h2; req_tc = 3'd6; req_valid = 1'b1;
    @(negedge clk);
    chk(desc_valid && desc_func == 3'd5, "R7 held request taken",
        {63'b0, desc_valid}, 64'h1);
    desc_ready = 1'b1;
    @(negedge clk);
    desc_ready = 1'b0;
    chk(req_ack == 1'b1, "R7 held request ack", {63'b0, req_ack}, 64'h1);
    req_valid = 1'b0;
    @(negedge clk);
    chk(desc_valid == 1'b0 && req_ack == 1'b0, "R7 no duplicate from held request",
        {62'b0, desc_valid, req_ack}, 64'h0);

    // R1: reset mid-transaction clears outputs
    pulse_req(3'd0, 5'h0, 3'd0);
    rst_n = 1'b0;
    @(negedge clk);
    chk(desc_valid == 1'b0 && req_ack == 1'b0, "R1 reset clears pending",
        {62'b0, desc_valid, req_ack}, 64'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule